// File: doc/BRIEF.md
# System Control Port Register

This block is a one-byte control register that a host reaches through a plain byte-wide I/O bus. The bus has an address, a write strobe, a read strobe and 8-bit write and read data. The register answers at exactly one I/O address, 0x92. A write there replaces the whole byte. A read there returns the byte unchanged.

Two bits of the byte have side effects:

- Bit 1 drives the fast gate for address line 20. The gate output copies bit 1 of the stored byte at all times.
- Bit 0 is a reset-request bit. A write that moves bit 0 from 0 to 1 produces a one-clock request pulse for the system reset controller.

The block has two resets. A power-on reset clears the whole byte. A warm reset clears only bit 0, so the gate setting and the spare bits survive a software-triggered restart. Masking the address line itself and acting on the reset request are left to neighbouring logic.

Top module: `sys_ctl_port`

## Requirements
- R1: Only a bus access whose full 16-bit address equals 0x92 reaches the register. A write to any other address, including aliases such as 0x192, leaves the stored byte unchanged.
- R2: A write to 0x92 stores all eight data bits. The new value is visible from the cycle after the write strobe edge.
- R3: `a20_gate` equals bit 1 of the stored byte. It therefore changes in the cycle after a write that alters bit 1.
- R4: `sys_rst_req` goes high for exactly one clock cycle, in the cycle after a write to 0x92. It fires only when that write carries 1 in bit 0 and the stored bit 0 was 0.
- R5: A write with bit 0 equal to 1 while stored bit 0 is already 1 raises no request. A write with bit 0 equal to 0 raises no request either.
- R6: While `bus_rd` is high and the address is 0x92, `bus_rdata` shows the full stored byte in the same cycle. When a write and a read hit together, the read shows the value from before the write.
- R7: While `por_n` is low at a clock edge, the register becomes 0x00. After that edge `a20_gate` and `sys_rst_req` are low.
- R8: While `warm_rst_n` is low at a clock edge with no write, bit 0 is cleared and bits 7 to 1 keep their values.
- R9: When a warm reset and a write coincide, bits 7 to 1 take the written value, bit 0 ends up 0, and no reset request is raised.
- R10: `bus_rdata` is 0x00 whenever `bus_rd` is low or the address is not 0x92.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears the whole byte |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low; clears bit 0 only |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational, zero unless a read hits 0x92 |
| a20_gate | output | 1 | Address line 20 gate, follows bit 1 |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench writes 1 to bit 0 twice in a row. A design that compared against the data instead of the stored bit would fire a second request. It then holds the pulse for a further cycle, where a level-type output would stay high. Alias addresses such as 0x93 and 0x192 are written to catch partial decoding, which would corrupt the byte. Coincident warm reset and write, and coincident read and write, are driven to catch reset priority turned around, which would leave bit 0 set and raise a request, and read data taken after the register updates, which would show the new byte early.

// File: rtl/sysctl_pkg.sv
// Package: shared sizes and defaults for the system control port.
// Assumes a byte-wide I/O bus with a 16-bit address space.
package sysctl_pkg;
    localparam int unsigned SYSCTL_ADDR_W   = 16;
    localparam int unsigned SYSCTL_DATA_W   = 8;
    localparam logic [15:0] SYSCTL_PORT_ADR = 16'h0092;
    localparam int unsigned SYSCTL_RST_BIT  = 0;
    localparam int unsigned SYSCTL_GATE_BIT = 1;
endpackage

// File: rtl/sysctl_decode.sv
// Module: full address compare that qualifies the bus strobes.
// Assumes one access per strobe cycle; no wait states.
module sysctl_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    // Compare every address bit so that aliases never respond.
    always_comb begin
        match  = (addr == PORT_ADR);
        wr_hit = wr & match;
        rd_hit = rd & match;
    end
endmodule

// File: rtl/sysctl_store.sv
// Module: the stored control byte with both reset flavours.
// Assumes por_n dominates; warm reset clears RST_BIT, also over a write.
module sysctl_store #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RST_BIT = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;

    logic [DATA_W-1:0] d;

    // Next value: write replaces the byte, warm reset then drops the reset bit.
    always_comb begin
        d = q;
        if (wr_en) d = wdata;
        if (!warm_n) d = d & ~RST_MASK;
    end

    // Register with synchronous power-on clear.
    always_ff @(posedge clk) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    AST_POR_CLEAR: assert property (@(posedge clk) !por_n |=> q == '0); // R7
    AST_WR_STORE: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && warm_n) |=> q == $past(wdata)); // R2
    AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_n && !wr_en) |=> q == ($past(q) & ~RST_MASK)); // R8
    AST_WARM_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_n && wr_en) |=> q == ($past(wdata) & ~RST_MASK)); // R9
endmodule

// File: rtl/sysctl_edge.sv
// Module: rising-edge detector on the reset bit, one-cycle request pulse.
// Assumes old_bit is the stored bit before the write lands.
module sysctl_edge (
    input  logic clk,
    input  logic por_n,
    input  logic warm_n,
    input  logic wr_en,
    input  logic new_bit,
    input  logic old_bit,
    output logic req
);
    // Pulse when a write sets the bit from 0; a coincident warm reset suppresses it.
    always_ff @(posedge clk) begin
        if (!por_n) req <= 1'b0;
        else        req <= wr_en & warm_n & new_bit & ~old_bit;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        req |=> !req); // R4
endmodule

// File: rtl/sys_ctl_port.sv
// Module: system control port top. Decodes one I/O address, holds the
// control byte, drives the address-20 gate and the reset request.
// Assumes a single-master byte bus with combinational read data.
module sys_ctl_port #(
    parameter int unsigned ADDR_W   = sysctl_pkg::SYSCTL_ADDR_W,
    parameter int unsigned DATA_W   = sysctl_pkg::SYSCTL_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADR = ADDR_W'(sysctl_pkg::SYSCTL_PORT_ADR),
    parameter int unsigned RST_BIT  = sysctl_pkg::SYSCTL_RST_BIT,
    parameter int unsigned GATE_BIT = sysctl_pkg::SYSCTL_GATE_BIT
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              a20_gate,
    output logic              sys_rst_req
);
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] ctl_q;

    sysctl_decode #(.ADDR_W(ADDR_W), .PORT_ADR(PORT_ADR)) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    sysctl_store #(.DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_store (
        .clk    (clk),
        .por_n  (por_n),
        .warm_n (warm_rst_n),
        .wr_en  (wr_hit),
        .wdata  (bus_wdata),
        .q      (ctl_q)
    );

    sysctl_edge u_edge (
        .clk     (clk),
        .por_n   (por_n),
        .warm_n  (warm_rst_n),
        .wr_en   (wr_hit),
        .new_bit (bus_wdata[RST_BIT]),
        .old_bit (ctl_q[RST_BIT]),
        .req     (sys_rst_req)
    );

    // Read mux: the stored byte on a hit, zero otherwise.
    always_comb bus_rdata = rd_hit ? ctl_q : '0;

    // Gate output straight from the stored bit.
    always_comb a20_gate = ctl_q[GATE_BIT];

    AST_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr == PORT_ADR) |=> a20_gate == $past(bus_wdata[GATE_BIT])); // R3
    AST_REQ_SETS_BIT: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_req |-> ctl_q[RST_BIT]); // R4
    AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_rd && bus_addr == PORT_ADR) |-> bus_rdata == '0); // R10
    AST_OTHER_ADR: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr != PORT_ADR && warm_rst_n) |=> ctl_q == $past(ctl_q)); // R1
endmodule

// File: tb/sys_ctl_port_bench.sv
`timescale 1ns/1ps
module sys_ctl_port_bench;
    logic        clk = 1'b0;
    logic        por_n;
    logic        warm_rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        a20_gate;
    logic        sys_rst_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sys_ctl_port u_sys_ctl_port (
        .clk         (clk),
        .por_n       (por_n),
        .warm_rst_n  (warm_rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .a20_gate    (a20_gate),
        .sys_rst_req (sys_rst_req)
    );

    // Vector: {addr[15:0], wdata[7:0], expected byte at 0x92 [7:0], expected pulse}
    localparam int NV = 8;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0092, 8'hA5, 8'hA5, 1'b1},  // R4 bit0 0->1
        {16'h0092, 8'hA7, 8'hA7, 1'b0},  // R5 bit0 already 1
        {16'h0093, 8'h00, 8'hA7, 1'b0},  // R1 neighbour address
        {16'h0092, 8'h02, 8'h02, 1'b0},  // R2 clear bit0, no pulse
        {16'h0192, 8'hFF, 8'h02, 1'b0},  // R1 alias address
        {16'h0092, 8'h03, 8'h03, 1'b1},  // R4 set again
        {16'h0092, 8'h00, 8'h00, 1'b0},  // R5 write zero
        {16'h0092, 8'h81, 8'h81, 1'b1}   // R4 high bit plus bit0
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Drive a read at 0x92 in the current low phase and sample it.
    task automatic read_byte(input string tag, input logic [7:0] exp);
        bus_addr = 16'h0092; bus_rd = 1'b1;
        #1 chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_n = 1'b0; warm_rst_n = 1'b1; bus_addr = '0; bus_wr = 1'b0;
        bus_wdata = '0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        read_byte("R7 por byte", 8'h00);
        chk("R7 por gate", {7'd0, a20_gate}, 8'h00);
        chk("R7 por req", {7'd0, sys_rst_req}, 8'h00);
        por_n = 1'b1;
        @(negedge clk);

        // Vector walk: write, then check pulse, gate and byte, then pulse end.
        for (int i = 0; i < NV; i++) begin
            bus_addr = VEC[i][32:17]; bus_wdata = VEC[i][16:9]; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            chk($sformatf("R4/R5 req v%0d", i), {7'd0, sys_rst_req}, {7'd0, VEC[i][0]});
            chk($sformatf("R3 gate v%0d", i), {7'd0, a20_gate}, {7'd0, VEC[i][2]});
            read_byte($sformatf("R1/R2 byte v%0d", i), VEC[i][8:1]);
            @(negedge clk);
            chk($sformatf("R4 pulse width v%0d", i), {7'd0, sys_rst_req}, 8'h00);
        end

        // R6: simultaneous write and read shows the old byte.
        bus_addr = 16'h0092; bus_wdata = 8'h57; bus_wr = 1'b1; bus_rd = 1'b1;
        #1 chk("R6 rd during wr", bus_rdata, 8'h81);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R5 no req 1 over 1", {7'd0, sys_rst_req}, 8'h00);
        read_byte("R6 new byte", 8'h57);

        // R8: warm reset alone clears bit 0 only.
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        read_byte("R8 warm keeps upper", 8'h56);
        chk("R8 gate kept", {7'd0, a20_gate}, 8'h01);

        // R9: warm reset coincident with a write.
        bus_addr = 16'h0092; bus_wdata = 8'hFF; bus_wr = 1'b1; warm_rst_n = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; warm_rst_n = 1'b1;
        chk("R9 no req", {7'd0, sys_rst_req}, 8'h00);
        read_byte("R9 byte", 8'hFE);

        // R10: reads that miss return zero.
        bus_addr = 16'h0093; bus_rd = 1'b1;
        #1 chk("R10 other addr", bus_rdata, 8'h00);
        bus_addr = 16'h0092; bus_rd = 1'b0;
        #1 chk("R10 no strobe", bus_rdata, 8'h00);

        // R7: power-on reset mid-run clears everything.
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        read_byte("R7 mid-run por", 8'h00);
        chk("R7 gate low", {7'd0, a20_gate}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule